// File: doc/BRIEF.md
# Step Attenuator Control Interface

This block is the digital front end that sets a 6-bit binary-weighted step attenuator. It produces the attenuation code from one of three sources: a six-bit serial shift register with a holding latch after it, a six-bit parallel input port used either latched or direct, or a default chosen when reset is released. A mode pin selects the serial or parallel path. A latch-enable pin decides when a new value reaches the output.

All external pins are asynchronous to the block. They pass through two-flop synchronizers into a fast system clock domain. That clock samples the external serial clock and the latch-enable line and finds their edges there, so the system clock must run at least four times faster than the fastest serial clock. The default applied after reset depends on the mode pin and the latch-enable level. In one parallel case it comes from two preset pins instead of the parallel port.

Top module: `atten_ctrl_frontend`

## Requirements
- R1: `code_o` bit 5 weighs 16 dB, then 8, 4, 2, 1 and bit 0 weighs 0.5 dB. All zeros is the reference loss and all ones is 31.5 dB. While `rst` is high, `code_o` is 0.
- R2: `ser_sel_i` = 1 selects the serial path and `ser_sel_i` = 0 selects the parallel path. The unselected source does not reach `code_o`.
- R3: On each rising edge of `sclk_i`, `sdata_i` enters the shift register at bit 0 and the older bits move up one place. After six clocks, the first bit sent sits at bit 5 (16 dB) and the last bit sent sits at bit 0.
- R4: In serial mode with `le_i` high, the latch is transparent and `code_o` follows the shift register, including partly shifted words.
- R5: In serial mode with `le_i` low, `code_o` holds its value. Shifting continues and does not disturb the output. A falling `le_i` keeps the register value that was showing.
- R6: In parallel mode with `le_i` high (direct mode), `code_o` follows `par_code_i`.
- R7: In parallel mode with `le_i` low, `code_o` holds. A high-then-low pulse on `le_i` captures `par_code_i` as it stands when `le_i` falls.
- R8: If reset is released in serial mode, or in parallel mode with `le_i` high, the first code is `par_code_i`. The same value is also loaded into the shift register.
- R9: If reset is released in parallel mode with `le_i` low, the first code comes from `preset_i` (bit 1 is the MSB): 00 gives 0x00, 01 gives 0x10 (8 dB), 10 gives 0x20 (16 dB) and 11 gives 0x3F (31.5 dB).
- R10: `preset_i` has no effect at any other time, including reset release in serial mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_sel_i | input | 1 | Path select: 1 = serial, 0 = parallel |
| le_i | input | 1 | Latch enable (asynchronous) |
| sclk_i | input | 1 | Serial clock (asynchronous) |
| sdata_i | input | 1 | Serial data, MSB first |
| par_code_i | input | 6 | Parallel attenuation code |
| preset_i | input | 2 | Power-up default select, parallel latched case only |
| code_o | output | 6 | Registered attenuation code |

## Verification
An input change on any level pin is captured by two synchronizer flops and then by the output register. A change to `par_code_i` in direct mode therefore shows on `code_o` after the third rising clock edge. The bench checks this exactly: the old value must still be present after two edges and the new value after three. A serial clock edge needs one more edge before a transparent latch shows it. The bench waits at least five edges after every serial bit or `le_i` change, then samples on the falling clock edge. After reset is released, the default is checked two cycles later. That is one cycle past the single cycle in which the default is chosen.

// File: rtl/atten_pkg.sv
package atten_pkg;
  localparam int CODE_W = 6;

  // default for the parallel, latch-closed power-up case
  function automatic logic [CODE_W-1:0] preset_code(input logic [1:0] sel);
    logic [CODE_W-1:0] v;
    case (sel)
      2'b00:   v = '0;
      2'b01:   v = (CODE_W)'(1) << (CODE_W - 2);
      2'b10:   v = (CODE_W)'(1) << (CODE_W - 1);
      default: v = '1;
    endcase
    return v;
  endfunction
endpackage

// File: rtl/atten_sync.sv
module atten_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) stg[0] <= d_i;

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) stg[i] <= stg[i-1];
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/atten_shreg.sv
module atten_shreg #(
  parameter int CODE_W = atten_pkg::CODE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              init_i,
  input  logic [CODE_W-1:0] init_val_i,
  input  logic              sclk_i,
  input  logic              sdata_i,
  output logic [CODE_W-1:0] shreg_o
);
  logic              sclk_prev;
  logic [CODE_W-1:0] sr_q;
  logic              rise;

  assign rise = sclk_i & ~sclk_prev;

  always_ff @(posedge clk) begin
    sclk_prev <= sclk_i;
    if (rst) begin
      sr_q <= '0;
    end else if (init_i) begin
      sr_q <= init_val_i;
    end else if (rise) begin
      sr_q <= {sr_q[CODE_W-2:0], sdata_i};
    end
  end

  assign shreg_o = sr_q;
endmodule

// File: rtl/atten_latch.sv
module atten_latch #(
  parameter int CODE_W = atten_pkg::CODE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              init_i,
  input  logic [CODE_W-1:0] init_val_i,
  input  logic              sel_i,
  input  logic              le_i,
  input  logic [CODE_W-1:0] par_i,
  input  logic [CODE_W-1:0] shreg_i,
  output logic [CODE_W-1:0] code_o
);
  logic              le_prev;
  logic [CODE_W-1:0] code_q;

  always_ff @(posedge clk) begin
    le_prev <= le_i;
    if (rst) begin
      code_q <= '0;
    end else if (init_i) begin
      code_q <= init_val_i;
    end else if (le_i) begin
      code_q <= sel_i ? shreg_i : par_i;
    end else if (le_prev && !sel_i) begin
      code_q <= par_i;
    end
  end

  assign code_o = code_q;
endmodule

// File: rtl/atten_ctrl_frontend.sv
module atten_ctrl_frontend #(
  parameter int CODE_W      = atten_pkg::CODE_W,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ser_sel_i,
  input  logic              le_i,
  input  logic              sclk_i,
  input  logic              sdata_i,
  input  logic [CODE_W-1:0] par_code_i,
  input  logic [1:0]        preset_i,
  output logic [CODE_W-1:0] code_o
);
  localparam int IN_W = CODE_W + 6;

  logic [IN_W-1:0]   pins_s;
  logic              ser_sel_s, le_s, sclk_s, sdata_s;
  logic [1:0]        pre_s;
  logic [CODE_W-1:0] par_s;
  logic [CODE_W-1:0] shreg_q;
  logic [CODE_W-1:0] init_val;
  logic              init_pend;

  atten_sync #(.W(IN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .d_i ({ser_sel_i, le_i, sclk_i, sdata_i, preset_i, par_code_i}),
    .q_o (pins_s)
  );

  assign {ser_sel_s, le_s, sclk_s, sdata_s, pre_s, par_s} = pins_s;

  // one decision cycle right after reset
  always_ff @(posedge clk) begin
    if (rst) init_pend <= 1'b1;
    else     init_pend <= 1'b0;
  end

  assign init_val = (ser_sel_s || le_s) ? par_s : atten_pkg::preset_code(pre_s);

  atten_shreg #(.CODE_W(CODE_W)) u_shreg (
    .clk        (clk),
    .rst        (rst),
    .init_i     (init_pend),
    .init_val_i (init_val),
    .sclk_i     (sclk_s),
    .sdata_i    (sdata_s),
    .shreg_o    (shreg_q)
  );

  atten_latch #(.CODE_W(CODE_W)) u_latch (
    .clk        (clk),
    .rst        (rst),
    .init_i     (init_pend),
    .init_val_i (init_val),
    .sel_i      (ser_sel_s),
    .le_i       (le_s),
    .par_i      (par_s),
    .shreg_i    (shreg_q),
    .code_o     (code_o)
  );
endmodule

// File: rtl/atten_ctrl_chk.sv
module atten_ctrl_chk #(
  parameter int CODE_W = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              sel_s,
  input logic              le_s,
  input logic              sclk_s,
  input logic              sdata_s,
  input logic [1:0]        pre_s,
  input logic [CODE_W-1:0] par_s,
  input logic [CODE_W-1:0] shreg,
  input logic [CODE_W-1:0] code
);
  logic after_rst, le_prev, sclk_prev, first;

  always_ff @(posedge clk) begin
    after_rst <= rst;
    le_prev   <= le_s;
    sclk_prev <= sclk_s;
  end

  assign first = after_rst;

  AST_RESET_ZERO: assert property (@(posedge clk) rst |=> (rst -> code == '0));  // R1
  AST_SHIFT_IN: assert property (@(posedge clk) disable iff (rst)
    (!first && sclk_s && !sclk_prev) |=> shreg == {$past(shreg[CODE_W-2:0]), $past(sdata_s)});  // R3
  AST_TRANSPARENT: assert property (@(posedge clk) disable iff (rst)
    (!first && le_s && sel_s) |=> code == $past(shreg));  // R4
  AST_HOLD_CLOSED: assert property (@(posedge clk) disable iff (rst)
    (!first && !le_s && !(le_prev && !sel_s)) |=> $stable(code));  // R5
  AST_DIRECT: assert property (@(posedge clk) disable iff (rst)
    (!first && le_s && !sel_s) |=> code == $past(par_s));  // R6
  AST_FALL_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    (!first && !le_s && le_prev && !sel_s) |=> code == $past(par_s));  // R7
  AST_INIT_PAR: assert property (@(posedge clk) disable iff (rst)
    (first && (sel_s || le_s)) |=> (code == $past(par_s) && shreg == $past(par_s)));  // R8
  AST_INIT_PRE_MAX: assert property (@(posedge clk) disable iff (rst)
    (first && !sel_s && !le_s && pre_s == 2'b11) |=> code == {CODE_W{1'b1}});  // R9
  AST_INIT_PRE_ZERO: assert property (@(posedge clk) disable iff (rst)
    (first && !sel_s && !le_s && pre_s == 2'b00) |=> code == '0);  // R9
endmodule

bind atten_ctrl_frontend atten_ctrl_chk #(.CODE_W(CODE_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .sel_s   (ser_sel_s),
  .le_s    (le_s),
  .sclk_s  (sclk_s),
  .sdata_s (sdata_s),
  .pre_s   (pre_s),
  .par_s   (par_s),
  .shreg   (shreg_q),
  .code    (code_o)
);

// File: tb/tb_atten_ctrl_frontend.sv
`timescale 1ns/1ps
module tb_atten_ctrl_frontend;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ser_sel = 1'b0;
  logic       le = 1'b0;
  logic       sclk = 1'b0;
  logic       sdata = 1'b0;
  logic [5:0] par = 6'h15;
  logic [1:0] pre = 2'b10;
  logic [5:0] code;
  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  atten_ctrl_frontend dut (
    .clk(clk), .rst(rst), .ser_sel_i(ser_sel), .le_i(le), .sclk_i(sclk),
    .sdata_i(sdata), .par_code_i(par), .preset_i(pre), .code_o(code)
  );

  task automatic wcyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [5:0] exp);
    n_run++;
    if (code !== exp) begin
      n_fail++;
      $display("FAIL %s: code_o=%02h expected %02h", tag, code, exp);
    end
  endtask

  task automatic do_reset(input logic s, input logic l, input logic [5:0] p, input logic [1:0] r);
    @(negedge clk);
    rst = 1'b1; ser_sel = s; le = l; par = p; pre = r; sclk = 1'b0;
    wcyc(4);
    rst = 1'b0;
    wcyc(2);
  endtask

  task automatic send_bit(input logic b);
    sdata = b; wcyc(2);
    sclk = 1'b1; wcyc(3);
    sclk = 1'b0; wcyc(3);
  endtask

  task automatic send_word(input logic [5:0] w);
    for (int i = 5; i >= 0; i--) send_bit(w[i]);
    wcyc(2);
  endtask

  task automatic t_reset_and_presets();
    logic [5:0] exp_map [4];
    exp_map[0] = 6'h00; exp_map[1] = 6'h10; exp_map[2] = 6'h20; exp_map[3] = 6'h3F;
    wcyc(5);
    chk("R1 zero during reset", 6'h00);
    rst = 1'b0; wcyc(2);
    chk("R9 preset 10 at start", 6'h20);
    for (int p = 0; p < 4; p++) begin
      do_reset(1'b0, 1'b0, 6'h15, 2'(p));
      chk("R9 preset map", exp_map[p]);
    end
  endtask

  task automatic t_parallel();
    pre = 2'b00; par = 6'h2A; wcyc(6);
    chk("R10 preset change ignored", 6'h3F);
    chk("R7 closed latch holds", 6'h3F);
    par = 6'h2C; wcyc(2);
    le = 1'b1; wcyc(5);
    le = 1'b0; wcyc(5);
    chk("R7 pulse capture", 6'h2C);
    par = 6'h01; wcyc(6);
    chk("R7 hold after pulse", 6'h2C);
    par = 6'h2C; le = 1'b1; wcyc(6);
    par = 6'h0A; wcyc(2);
    chk("R6 direct not yet due", 6'h2C);
    wcyc(1);
    chk("R6 direct on third edge", 6'h0A);
    par = 6'h3F; wcyc(5);
    chk("R6 direct follow", 6'h3F);
    le = 1'b0; wcyc(5);
  endtask

  task automatic t_serial();
    do_reset(1'b1, 1'b0, 6'h2A, 2'b11);
    chk("R8 serial init from parallel port / R10", 6'h2A);
    le = 1'b1; wcyc(6);
    chk("R8 shift register loaded", 6'h2A);
    le = 1'b0; wcyc(5);
    send_word(6'h31);
    chk("R5 shifting with latch closed", 6'h2A);
    le = 1'b1; wcyc(6);
    chk("R3 MSB-first word", 6'h31);
    le = 1'b0; wcyc(5);
    send_word(6'h0E);
    chk("R5 latch held after fall", 6'h31);
    le = 1'b1; wcyc(6);
    send_bit(1'b1); wcyc(2);
    chk("R4 transparent partial word", 6'h1D);
    le = 1'b0; wcyc(5);
    send_bit(1'b0); wcyc(2);
    chk("R5 hold while shifting", 6'h1D);
    le = 1'b1; par = 6'h07; wcyc(6);
    chk("R2 serial ignores parallel port", 6'h3A);
    ser_sel = 1'b0; wcyc(6);
    chk("R2 parallel path selected", 6'h07);
    do_reset(1'b0, 1'b1, 6'h19, 2'b10);
    chk("R8 direct-mode init / R10", 6'h19);
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    t_reset_and_presets();
    t_parallel();
    t_serial();
    done = 1'b1;
    summary();
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      summary();
    end
  end
endmodule